// File: doc/BRIEF.md
# Periodic Preload Down-Counter Timer

The block is a programmable down-counter with a 24-bit reload value and an interrupt request output. Software loads the reload value one byte at a time, sets a control byte and turns the timer on. While it runs, the counter steps down once every 32 system clocks. Each time a step finds the counter at zero, the block raises a zero-detect flag. The counter then either starts again from the reload value or wraps to all ones, depending on a mode bit.

The flag drives the interrupt request pin when the output-mode field selects request-and-acknowledge operation. When the processor acknowledges through the acknowledge input, the block drives its 8-bit vector byte onto the read bus. Software clears the flag by writing a one to it. The live counter can be read without tearing: reading its high byte captures the two lower bytes for the reads that follow.

Top module: `ptmr_top`

## Requirements
- R1: After reset the control byte reads 0x00, the vector byte reads 0x0F, and the status byte, every reload byte and every counter byte read 0x00. The request output is low.
- R2: Register addresses are: control 0, vector 1, status 2, reload high/middle/low at 4/5/6, counter high/middle/low at 8/9/10. Control, vector and reload bytes read back as written. The control byte layout is: bit 0 enable, bits 2:1 count-clock select, bit 4 zero mode, bits 7:5 output mode.
- R3: A write that changes the enable bit from 0 to 1 loads the counter from the reload value and restarts the divide-by-32 prescaler. With clock select 00, the first decrement happens on the 32nd clock edge after that write edge.
- R4: In reload mode (control bit 4 = 0), a count step that finds the counter at zero sets status bit 0 and reloads the counter. For a reload value P, the flag therefore rises exactly 32*(P+1) edges after the enabling write.
- R5: In roll mode (control bit 4 = 1), a count step at zero sets the flag and leaves the counter at 0xFFFFFF.
- R6: The counter holds its value while the enable bit is 0 or the clock select is not 00.
- R7: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. If a zero-detect step occurs in the same cycle as the clear, the flag stays set.
- R8: The request output is high exactly when the flag is set and the output mode is 101.
- R9: Reading counter byte 8 latches the middle and low counter bytes. Later reads of bytes 9 and 10 return the latched values even after the counter has moved on.
- R10: While the acknowledge input is high and the output mode is 101, the read bus carries the vector byte whatever the address. In other output modes the acknowledge input is ignored.
- R11: A reload write made while the timer is running does not change the counter until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data or vector during acknowledge |
| tmr_iack | input | 1 | Interrupt acknowledge |
| tmr_irq | output | 1 | Interrupt request |

## Verification
A prescaler phase error shows up at the request pin as a flag that is one or more clocks early or late. The bench checks the pin on the exact edge 32*(P+1) after enabling, and on the edge before it. A wrong counter step or reload value shows up one period later, as a second request on the wrong edge, or as a wrong byte in a counter read. A snapshot that is not held shows up at the next low-byte read, and a flag-update ordering error shows up on the read that follows a clear landing on a terminal step.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_VEC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_PRE  = 4'd4;  // high byte, then lower bytes upward
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd8;  // high byte, then lower bytes upward
  localparam logic [2:0] OM_REQ_ACK = 3'b101;
  localparam logic [1:0] CS_DIV     = 2'b00;
  localparam logic [7:0] VEC_RST    = 8'h0F;

  typedef struct packed {
    logic [2:0] omode;
    logic       roll;
    logic       spare;
    logic [1:0] csel;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/ptmr_presc.sv
module ptmr_presc #(
  parameter int PRESC_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  logic [PRESC_W-1:0] div_q, div_d;

  assign tick = run && (div_q == '1);

  always_comb begin
    div_d = div_q;
    if (clr)      div_d = '0;
    else if (run) div_d = div_q + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core #(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic              roll_mode,
  input  logic [CNT_W-1:0]  preload,
  input  logic              rd_hi,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-9:0]  snap,
  output logic              zd_set
);
  localparam int SNAP_W = CNT_W - 8;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SNAP_W-1:0] snap_q, snap_d;
  logic              at_zero;

  assign at_zero = (cnt_q == '0);
  assign zd_set  = tick && at_zero && !load;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = preload;
    end else if (tick) begin
      if (at_zero) cnt_d = roll_mode ? '1 : preload;
      else         cnt_d = cnt_q - CNT_W'(1);
    end
  end

  assign snap_d = rd_hi ? cnt_q[SNAP_W-1:0] : snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      snap_q <= snap_d;
    end
  end

  assign count = cnt_q;
  assign snap  = snap_q;
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              zd_set,
  output ctrl_t             ctrl,
  output logic [7:0]        vec,
  output logic [CNT_W-1:0]  preload,
  output logic              zd_flag,
  output logic              en_rise,
  output logic              stat_clr
);
  localparam int NB = CNT_W / 8;

  ctrl_t      ctrl_q, ctrl_d;
  logic [7:0] vec_q, vec_d;
  logic       zd_q, zd_d;
  logic       hit_ctrl;

  assign hit_ctrl = wr_en && (addr == A_CTRL);
  assign en_rise  = hit_ctrl && wdata[0] && !ctrl_q.en;
  assign stat_clr = wr_en && (addr == A_STAT) && wdata[0];

  always_comb begin
    ctrl_d = hit_ctrl ? ctrl_t'(wdata) : ctrl_q;
    vec_d  = (wr_en && addr == A_VEC) ? wdata : vec_q;
    zd_d   = zd_set || (zd_q && !stat_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      vec_q  <= VEC_RST;
      zd_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      vec_q  <= vec_d;
      zd_q   <= zd_d;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_pre
    logic [7:0] byte_q, byte_d;
    logic       hit;
    assign hit    = wr_en && (addr == A_PRE + ADDR_W'(NB - 1 - b));
    assign byte_d = hit ? wdata : byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end
    assign preload[b*8 +: 8] = byte_q;
  end

  assign ctrl    = ctrl_q;
  assign vec     = vec_q;
  assign zd_flag = zd_q;
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int PRESC_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tmr_iack,
  output logic       tmr_irq
);
  localparam int NB = CNT_W / 8;

  logic             rst_meta_q, rst_sync_n;
  logic             wr_en, rd_en, rd_hi, run, tick;
  logic             zd_set, zd_flag, en_rise, stat_clr, ack_act;
  ctrl_t            ctrl;
  logic [7:0]       vec;
  logic [CNT_W-1:0] preload, count;
  logic [CNT_W-9:0] snap;
  logic [7:0]       rdata_c;

  // reset: asserted at once, released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign wr_en   = bus_sel && bus_wr;
  assign rd_en   = bus_sel && !bus_wr;
  assign rd_hi   = rd_en && (bus_addr == A_CNT);
  assign run     = ctrl.en && (ctrl.csel == CS_DIV);
  assign ack_act = tmr_iack && (ctrl.omode == OM_REQ_ACK);
  assign tmr_irq = zd_flag && (ctrl.omode == OM_REQ_ACK);

  ptmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .zd_set(zd_set), .ctrl(ctrl), .vec(vec),
    .preload(preload), .zd_flag(zd_flag), .en_rise(en_rise), .stat_clr(stat_clr)
  );

  ptmr_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .clr(en_rise), .tick(tick)
  );

  ptmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .load(en_rise),
    .roll_mode(ctrl.roll), .preload(preload), .rd_hi(rd_hi),
    .count(count), .snap(snap), .zd_set(zd_set)
  );

  always_comb begin
    rdata_c = '0;
    if (ack_act) begin
      rdata_c = vec;
    end else if (rd_en) begin
      if (bus_addr == A_CTRL) rdata_c = ctrl;
      if (bus_addr == A_VEC)  rdata_c = vec;
      if (bus_addr == A_STAT) rdata_c = {7'd0, zd_flag};
      if (bus_addr == A_CNT)  rdata_c = count[CNT_W-1 -: 8];
      for (int b = 0; b < NB; b++) begin
        if (bus_addr == A_PRE + ADDR_W'(NB - 1 - b)) rdata_c = preload[b*8 +: 8];
      end
      for (int b = 0; b < NB - 1; b++) begin
        if (bus_addr == A_CNT + ADDR_W'(NB - 1 - b)) rdata_c = snap[b*8 +: 8];
      end
    end
  end

  assign bus_rdata = rdata_c;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             en_rise,
  input logic             stat_clr,
  input logic             zd_set,
  input logic             zd_flag,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] preload,
  input logic [CNT_W-9:0] snap,
  input logic             rd_hi,
  input logic             ack_act,
  input logic [7:0]       rdata,
  input logic [7:0]       vec,
  input logic [2:0]       omode,
  input logic             irq
);
  // R3
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> count == $past(preload));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == '0 && !en_rise) |=> zd_flag);

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !en_rise) |=> $stable(count));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !zd_set) |=> !zd_flag);

  // R8
  irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (omode != 3'b101) |-> !irq);

  // R9
  snap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> snap == $past(count[CNT_W-9:0]));

  // R10
  ack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_act |-> rdata == vec);
endmodule

bind ptmr_top ptmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick(tick), .en_rise(en_rise),
  .stat_clr(stat_clr), .zd_set(zd_set), .zd_flag(zd_flag), .count(count),
  .preload(preload), .snap(snap), .rd_hi(rd_hi), .ack_act(ack_act),
  .rdata(bus_rdata), .vec(vec), .omode(ctrl.omode), .irq(tmr_irq)
);

// File: tb/ptmr_top_tb.sv
`timescale 1ns/1ps
module ptmr_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr, tmr_iack;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       tmr_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_edge = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ptmr_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_iack(tmr_iack), .tmr_irq(tmr_irq)
  );

  // row: {write, addr[3:0], data[7:0], expected[7:0]}
  localparam int NROWS = 16;
  localparam logic [20:0] TAB [NROWS] = '{
    {1'b0, 4'd0, 8'h00, 8'h00}, {1'b0, 4'd1, 8'h00, 8'h0F},
    {1'b0, 4'd2, 8'h00, 8'h00}, {1'b0, 4'd4, 8'h00, 8'h00},
    {1'b0, 4'd8, 8'h00, 8'h00}, {1'b1, 4'd1, 8'h46, 8'h00},
    {1'b0, 4'd1, 8'h00, 8'h46}, {1'b1, 4'd4, 8'h12, 8'h00},
    {1'b1, 4'd5, 8'h34, 8'h00}, {1'b1, 4'd6, 8'h56, 8'h00},
    {1'b0, 4'd4, 8'h00, 8'h12}, {1'b0, 4'd5, 8'h00, 8'h34},
    {1'b0, 4'd6, 8'h00, 8'h56}, {1'b1, 4'd0, 8'hA0, 8'h00},
    {1'b0, 4'd0, 8'h00, 8'hA0}, {1'b0, 4'd8, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    last_edge = cyc;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic rd_cnt(output logic [23:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd8;
    #1 v[23:16] = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_addr = 4'd9;  #1 v[15:8] = bus_rdata;
    bus_addr = 4'd10; #1 v[7:0]  = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_edge(input int n);
    while (cyc < n) begin @(posedge clk); #1; end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0]  b;
    logic [23:0] c;
    int e;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; tmr_iack = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R1 irq after reset", tmr_irq, 0);

    // table walk: R1 reset values, R2 read-back
    for (int i = 0; i < NROWS; i++) begin
      if (TAB[i][20]) wr(TAB[i][19:16], TAB[i][15:8]);
      else begin
        rd(TAB[i][19:16], b);
        chk((i < 5) ? "R1 table" : "R2 table", b, TAB[i][7:0]);
      end
    end

    // R3 first step timing, R9 snapshot
    wr(4'd4, 8'h00); wr(4'd5, 8'h00); wr(4'd6, 8'h05);
    wr(4'd0, 8'hA1); e = last_edge;
    wait_edge(e + 31);
    rd_cnt(c); chk("R3 count before first step", c, 24'h000005);
    rd_cnt(c); chk("R3 count after first step", c, 24'h000004);
    wait_edge(e + 100);
    rd(4'd10, b); chk("R9 low byte held in snapshot", b, 8'h04);
    rd(4'd8, b);  chk("R9 high byte live", b, 8'h00);

    // R4 / R8 / R11 reload period
    wr(4'd0, 8'hA0); wr(4'd2, 8'h01);
    wr(4'd6, 8'h03);
    wr(4'd0, 8'hA1); e = last_edge;
    wr(4'd6, 8'h10);  // R11: new reload value while running
    wait_edge(e + 127); chk("R4 no flag one edge early", tmr_irq, 0);
    wait_edge(e + 128); chk("R8 request on flag", tmr_irq, 1);
    rd(4'd2, b); chk("R4 status flag set", b, 8'h01);
    wr(4'd2, 8'h00); chk("R7 write 0 keeps flag", tmr_irq, 1);
    tmr_iack = 1'b1;
    rd(4'd0, b); chk("R10 vector on acknowledge", b, 8'h46);
    tmr_iack = 1'b0;
    wr(4'd2, 8'h01); chk("R7 clear drops request", tmr_irq, 0);
    wait_edge(e + 128 + 543); chk("R11 no flag before new period", tmr_irq, 0);
    wait_edge(e + 128 + 544); chk("R11 flag after new-period reload", tmr_irq, 1);

    // R8 / R10 other output mode
    wr(4'd0, 8'h21);
    chk("R8 request masked in mode 001", tmr_irq, 0);
    tmr_iack = 1'b1;
    rd(4'd0, b); chk("R10 acknowledge ignored", b, 8'h21);
    tmr_iack = 1'b0;

    // R6 hold with non-00 clock select
    wr(4'd0, 8'h00); wr(4'd2, 8'h01);
    wr(4'd0, 8'h03); e = last_edge;
    wait_edge(e + 100);
    rd_cnt(c); chk("R6 counter holds", c, 24'h000010);

    // R5 roll mode
    wr(4'd0, 8'h00); wr(4'd6, 8'h01);
    wr(4'd0, 8'h11); e = last_edge;
    wait_edge(e + 70);
    rd_cnt(c); chk("R5 roll to all ones", c, 24'hFFFFFF);
    rd(4'd2, b); chk("R5 flag set on roll", b, 8'h01);
    chk("R8 no request in mode 000", tmr_irq, 0);

    // R7 set wins over clear
    wr(4'd0, 8'h00); wr(4'd6, 8'h00); wr(4'd2, 8'h01);
    wr(4'd0, 8'h01); e = last_edge;
    wait_edge(e + 40);
    wr(4'd2, 8'h01);
    rd(4'd2, b); chk("R7 clear between steps", b, 8'h00);
    wait_edge(e + 63);
    wr(4'd2, 8'h01);
    chk("R7 clear landed on step edge", last_edge, e + 64);
    rd(4'd2, b); chk("R7 set wins over clear", b, 8'h01);

    summary();
  end
endmodule